// File: doc/BRIEF.md
# EEPROM Status and Write-Protection Unit

This block owns the status byte of a serial EEPROM and decides whether each array write or status write may begin. It keeps three pieces of state: the write-enable latch, two block-protect bits and the busy flag. The command decoder of the serial slave sends one-cycle strobes for write-enable and write-disable. At the point where it would start a self-timed write, it raises a request for an array write (with its target address) or for a status write (with the received data byte). The unit answers in the same cycle with a grant or a deny. A granted request makes the unit busy from the next cycle until the write timer pulses its end-of-cycle input.

A status write changes only the two block-protect bits. The new value is held aside while the status write cycle runs and is copied into the active bits when that cycle ends. The active bits select a protected region: the top quarter, the top half or the whole array. An array write whose page falls in that region is refused. The active-low write-protect pin clears the write-enable latch and keeps it clear, which blocks both kinds of write. It cannot cut short a cycle that is already running. The array size (256 or 512 bytes) and the page size are parameters. Retention of the protect bits is modelled with ordinary registers.

Top module: `eeprom_status_guard`

## Requirements
- R1: `status_o` always reads bits 7..4 = 4'b1111, bit 3 = upper protect bit, bit 2 = lower protect bit, bit 1 = write-enable latch, bit 0 = busy. It is valid in every cycle, including while busy.
- R2: After reset the busy flag and the latch are 0 and the protect bits equal `BP_INIT` (default 2'b00), so the status reads 8'hF0.
- R3: A write-enable strobe sets the latch in the next cycle, and a write-disable strobe clears it. If both strobes arrive together, the latch is cleared. While `wp_ni` is 0 the latch is cleared in the next cycle and write-enable strobes are ignored.
- R4: Both kinds of request are denied while the latch is 0, while busy, or while `wp_ni` is 0. In the cycle of a request exactly one of its grant and deny outputs is 1; with no request both are 0.
- R5: A granted request sets busy in the next cycle. While busy, a pulse on `cycle_done_i` clears both busy and the latch in the next cycle. A pulse on `cycle_done_i` while not busy has no effect.
- R6: A granted status write takes data bits 3:2 as the new protect value and ignores the other data bits. The old protect bits stay visible and in force until the status write cycle ends; they change in the cycle after its `cycle_done_i`.
- R7: Protect code 2'b01 protects addresses from 3/4 of the array size upward, 2'b10 from 1/2, 2'b11 from 0, and 2'b00 protects nothing. With 512 bytes the starts are 0x180, 0x100 and 0x000. An array write is denied when the start of its page lies in the protected range.
- R8: Driving `wp_ni` low during a running cycle does not end it. Busy stays 1 until `cycle_done_i`, and a pending protect value is still committed then.
- R9: If an array write request and a status write request arrive in the same cycle, only the array write can be granted and the status write is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wren_i | input | 1 | Write-enable command strobe |
| cmd_wrdi_i | input | 1 | Write-disable command strobe |
| write_req_i | input | 1 | Request to start an array write cycle |
| write_addr_i | input | ADDR_W | Target address of the array write |
| wrsr_req_i | input | 1 | Request to start a status write cycle |
| wrsr_data_i | input | 8 | Status byte received with the status write |
| wp_ni | input | 1 | Write-protect pin, active low |
| cycle_done_i | input | 1 | End of the self-timed write cycle |
| status_o | output | 8 | Status byte |
| write_grant_o | output | 1 | Array write accepted |
| write_deny_o | output | 1 | Array write refused |
| wrsr_grant_o | output | 1 | Status write accepted |
| wrsr_deny_o | output | 1 | Status write refused |

## Verification
The hardest situation to reach is one in which a status write has been accepted, so a new protect value is pending, and `wp_ni` then drops before the cycle ends. The old protect bits must stay visible, busy must hold, and the new value must still appear after the end pulse. The stimulus sets the latch, issues a status write with code 2'b11, pulls the pin low for several busy cycles and only then pulses the end of cycle. Every protect code is also probed with array writes at the first address of the protected range and at the last byte of the page just below it.

// File: rtl/eeprom_stat_pkg.sv
package eeprom_stat_pkg;

  typedef enum logic [1:0] {
    BP_NONE    = 2'b00,
    BP_QUARTER = 2'b01,
    BP_HALF    = 2'b10,
    BP_ALL     = 2'b11
  } bp_e;

  typedef enum logic {
    CYC_ARRAY  = 1'b0,
    CYC_STATUS = 1'b1
  } cyc_kind_e;

  localparam logic [3:0] STAT_FIXED_HI = 4'hF;
  localparam int unsigned STAT_BP_LSB = 2;

endpackage

// File: rtl/stat_wel.sv
module stat_wel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_cmd_i,
  input  logic cycle_end_i,
  input  logic wp_ni,
  output logic wel_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          wel_o <= 1'b0;
    else if (!wp_ni)      wel_o <= 1'b0;
    else if (cycle_end_i) wel_o <= 1'b0;
    else if (clr_cmd_i)   wel_o <= 1'b0;
    else if (set_i)       wel_o <= 1'b1;
  end

endmodule

// File: rtl/stat_bp_store.sv
module stat_bp_store
  import eeprom_stat_pkg::*;
#(
  parameter logic [1:0] BP_INIT = 2'b00
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  bp_e  load_val_i,
  input  logic commit_i,
  output bp_e  bp_o
);

  bp_e pend_q;

  // pending copy is taken at grant, active copy only at cycle end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= bp_e'(BP_INIT);
      bp_o   <= bp_e'(BP_INIT);
    end else begin
      if (load_i)   pend_q <= load_val_i;
      if (commit_i) bp_o   <= pend_q;
    end
  end

endmodule

// File: rtl/stat_range_chk.sv
module stat_range_chk
  import eeprom_stat_pkg::*;
#(
  parameter int unsigned MEM_BYTES  = 512,
  parameter int unsigned PAGE_BYTES = 16,
  parameter int unsigned ADDR_W     = $clog2(MEM_BYTES)
) (
  input  bp_e               bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              protected_o
);

  localparam int unsigned PAGE_W = $clog2(PAGE_BYTES);
  localparam int unsigned CMP_W  = ADDR_W + 1;

  logic [CMP_W-1:0] start_w [4];
  logic [CMP_W-1:0] page_base;

  for (genvar g = 0; g < 4; g++) begin : g_start
    // code 0 protects nothing, 3 protects all, else g quarters from the top
    localparam int unsigned SIZE = (g == 3) ? MEM_BYTES : (MEM_BYTES / 4) * g;
    assign start_w[g] = CMP_W'(MEM_BYTES - SIZE);
  end

  assign page_base   = {1'b0, addr_i[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};
  assign protected_o = page_base >= start_w[bp_i];

endmodule

// File: rtl/eeprom_status_guard.sv
module eeprom_status_guard
  import eeprom_stat_pkg::*;
#(
  parameter int unsigned MEM_BYTES  = 512,
  parameter int unsigned PAGE_BYTES = 16,
  parameter logic [1:0]  BP_INIT    = 2'b00,
  parameter int unsigned ADDR_W     = $clog2(MEM_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wren_i,
  input  logic              cmd_wrdi_i,
  input  logic              write_req_i,
  input  logic [ADDR_W-1:0] write_addr_i,
  input  logic              wrsr_req_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic              wp_ni,
  input  logic              cycle_done_i,
  output logic [7:0]        status_o,
  output logic              write_grant_o,
  output logic              write_deny_o,
  output logic              wrsr_grant_o,
  output logic              wrsr_deny_o
);

  logic      busy_q;
  cyc_kind_e kind_q;
  logic      wel;
  bp_e       bp_act;
  logic      addr_prot;
  logic      cyc_end;
  logic      may_write;

  assign cyc_end   = cycle_done_i & busy_q;
  assign may_write = wel & ~busy_q & wp_ni;

  stat_wel u_wel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (cmd_wren_i),
    .clr_cmd_i   (cmd_wrdi_i),
    .cycle_end_i (cyc_end),
    .wp_ni       (wp_ni),
    .wel_o       (wel)
  );

  stat_bp_store #(.BP_INIT(BP_INIT)) u_bp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wrsr_grant_o),
    .load_val_i (bp_e'(wrsr_data_i[STAT_BP_LSB +: 2])),
    .commit_i   (cyc_end & (kind_q == CYC_STATUS)),
    .bp_o       (bp_act)
  );

  stat_range_chk #(
    .MEM_BYTES  (MEM_BYTES),
    .PAGE_BYTES (PAGE_BYTES),
    .ADDR_W     (ADDR_W)
  ) u_range (
    .bp_i        (bp_act),
    .addr_i      (write_addr_i),
    .protected_o (addr_prot)
  );

  // array write wins over a simultaneous status write
  assign write_grant_o = write_req_i & may_write & ~addr_prot;
  assign write_deny_o  = write_req_i & ~write_grant_o;
  assign wrsr_grant_o  = wrsr_req_i & may_write & ~write_req_i;
  assign wrsr_deny_o   = wrsr_req_i & ~wrsr_grant_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      kind_q <= CYC_ARRAY;
    end else if (write_grant_o) begin
      busy_q <= 1'b1;
      kind_q <= CYC_ARRAY;
    end else if (wrsr_grant_o) begin
      busy_q <= 1'b1;
      kind_q <= CYC_STATUS;
    end else if (cyc_end) begin
      busy_q <= 1'b0;
    end
  end

  assign status_o = {STAT_FIXED_HI, bp_act, wel, busy_q};

endmodule

// File: rtl/eeprom_status_guard_chk.sv
module eeprom_status_guard_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_wren_i,
  input logic       cmd_wrdi_i,
  input logic       write_req_i,
  input logic       wrsr_req_i,
  input logic       wp_ni,
  input logic       cycle_done_i,
  input logic [7:0] status_o,
  input logic       write_grant_o,
  input logic       write_deny_o,
  input logic       wrsr_grant_o,
  input logic       wrsr_deny_o
);

  p_fixed_hi_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7:4] == 4'hF);

  p_wp_clears_wel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wp_ni |=> !status_o[1]);

  p_wren_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wren_i && !cmd_wrdi_i && wp_ni && !(cycle_done_i && status_o[0]))
    |=> status_o[1]);

  p_no_grant_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] |-> (!write_grant_o && !wrsr_grant_o));

  p_one_answer_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (write_grant_o + write_deny_o == 2'(write_req_i)) &&
    (wrsr_grant_o + wrsr_deny_o == 2'(wrsr_req_i)));

  p_grant_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (write_grant_o || wrsr_grant_o) |=> status_o[0]);

  p_done_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_done_i && status_o[0]) |=> (!status_o[0] && !status_o[1]));

  p_bp_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cycle_done_i && status_o[0]) |=> $stable(status_o[3:2]));

  p_hold_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && !cycle_done_i) |=> status_o[0]);

  p_one_grant_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(write_grant_o && wrsr_grant_o));

endmodule

bind eeprom_status_guard eeprom_status_guard_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_wren_i    (cmd_wren_i),
  .cmd_wrdi_i    (cmd_wrdi_i),
  .write_req_i   (write_req_i),
  .wrsr_req_i    (wrsr_req_i),
  .wp_ni         (wp_ni),
  .cycle_done_i  (cycle_done_i),
  .status_o      (status_o),
  .write_grant_o (write_grant_o),
  .write_deny_o  (write_deny_o),
  .wrsr_grant_o  (wrsr_grant_o),
  .wrsr_deny_o   (wrsr_deny_o)
);

// File: tb/sim_eeprom_status_guard.sv
module sim_eeprom_status_guard;
  localparam int CLK_P = 10;
  localparam int MEM   = 512;
  localparam int PAGE  = 16;
  localparam int AW    = 9;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_wren_i = 0, cmd_wrdi_i = 0, write_req_i = 0, wrsr_req_i = 0;
  logic [AW-1:0] write_addr_i = '0;
  logic [7:0] wrsr_data_i = '0;
  logic wp_ni = 1'b1, cycle_done_i = 1'b0;
  logic [7:0] status_o;
  logic write_grant_o, write_deny_o, wrsr_grant_o, wrsr_deny_o;

  always #(CLK_P/2) clk = ~clk;

  eeprom_status_guard #(.MEM_BYTES(MEM), .PAGE_BYTES(PAGE)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_wren_i(cmd_wren_i), .cmd_wrdi_i(cmd_wrdi_i),
    .write_req_i(write_req_i), .write_addr_i(write_addr_i), .wrsr_req_i(wrsr_req_i),
    .wrsr_data_i(wrsr_data_i), .wp_ni(wp_ni), .cycle_done_i(cycle_done_i),
    .status_o(status_o), .write_grant_o(write_grant_o), .write_deny_o(write_deny_o),
    .wrsr_grant_o(wrsr_grant_o), .wrsr_deny_o(wrsr_deny_o));

  typedef struct {
    string      rq;
    bit         is_grant;
    logic [7:0] exp;
  } item_t;

  item_t q[$];
  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  // reference state
  logic m_busy = 0, m_wel = 0, m_kind = 0;
  logic [1:0] m_bp = 2'b00, m_pend = 2'b00;

  // monitor: checks every queued item a quarter period after the driving edge
  initial forever begin
    @(negedge clk);
    #(CLK_P/4);
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      act = it.is_grant ? {4'h0, write_grant_o, write_deny_o, wrsr_grant_o, wrsr_deny_o}
                        : status_o;
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s %s actual=%h expected=%h", it.rq,
                 it.is_grant ? "grants" : "status", act, it.exp);
      end
    end
  end

  function automatic logic [AW:0] prot_start(input logic [1:0] b);
    case (b)
      2'b01:   return (AW+1)'(MEM * 3 / 4);
      2'b10:   return (AW+1)'(MEM / 2);
      2'b11:   return '0;
      default: return (AW+1)'(MEM);
    endcase
  endfunction

  task automatic step(input logic wren, input logic wrdi, input logic wreq,
                      input logic sreq, input logic [7:0] sd, input logic [AW-1:0] a,
                      input logic wp, input logic done, input string rq);
    logic ok, prot, wg, wd, sg, sdn, dn;
    item_t it;
    @(negedge clk);
    cmd_wren_i = wren; cmd_wrdi_i = wrdi; write_req_i = wreq; wrsr_req_i = sreq;
    wrsr_data_i = sd; write_addr_i = a; wp_ni = wp; cycle_done_i = done;
    ok   = m_wel && !m_busy && wp;
    prot = ({1'b0, a} & ~(AW+1)'(PAGE - 1)) >= prot_start(m_bp);
    wg   = wreq && ok && !prot;
    wd   = wreq && !wg;
    sg   = sreq && ok && !wreq;
    sdn  = sreq && !sg;
    it.rq = rq; it.is_grant = 0; it.exp = {4'hF, m_bp, m_wel, m_busy};
    q.push_back(it);
    it.is_grant = 1; it.exp = {4'h0, wg, wd, sg, sdn};
    q.push_back(it);
    dn = done && m_busy;
    if (!wp) m_wel = 0;
    else if (dn) m_wel = 0;
    else if (wrdi) m_wel = 0;
    else if (wren) m_wel = 1;
    if (wg || sg) begin
      m_busy = 1; m_kind = sg;
      if (sg) m_pend = sd[3:2];
    end else if (dn) begin
      m_busy = 0;
      if (m_kind) m_bp = m_pend;
    end
  endtask

  task automatic idle(input string rq, input logic wp = 1);
    step(0, 0, 0, 0, 8'h00, '0, wp, 0, rq);
  endtask
  task automatic wren(input string rq);
    step(1, 0, 0, 0, 8'h00, '0, 1, 0, rq);
  endtask
  task automatic wreq(input logic [AW-1:0] a, input string rq);
    step(0, 0, 1, 0, 8'h00, a, 1, 0, rq);
  endtask
  task automatic sreq(input logic [7:0] d, input string rq);
    step(0, 0, 0, 1, d, '0, 1, 0, rq);
  endtask
  task automatic done(input string rq, input logic wp = 1);
    step(0, 0, 0, 0, 8'h00, '0, wp, 1, rq);
  endtask
  task automatic set_bp(input logic [7:0] d, input string rq);
    wren(rq); sreq(d, rq); idle(rq); done(rq); idle(rq);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    idle("R2 reset state");
    idle("R2 reset state");
    // R4: latch clear -> deny both
    wreq(9'h010, "R4 write without latch");
    sreq(8'h0C, "R4 status write without latch");
    // R3: set / clear / both together
    wren("R3 set latch");
    idle("R3 latch set");
    step(0, 1, 0, 0, 8'h00, '0, 1, 0, "R3 write-disable");
    idle("R3 latch cleared");
    wren("R3 set again");
    step(1, 1, 0, 0, 8'h00, '0, 1, 0, "R3 both strobes");
    idle("R3 both strobes clear");
    // R5 granted array write, busy, status readable
    wren("R5 set");
    wreq(9'h010, "R5 array write grant");
    wren("R1 read while busy");
    wreq(9'h020, "R4 write while busy");
    sreq(8'h0C, "R4 status write while busy");
    idle("R1 status repeat");
    done("R5 cycle end");
    idle("R5 after end");
    done("R5 stray end ignored");
    idle("R5 stray end ignored");
    // R6: pending protect value, old visible until end
    wren("R6 set");
    sreq(8'hF7, "R6 status write code 01");
    idle("R6 old bits held");
    idle("R6 old bits held");
    done("R6 commit");
    idle("R6 new bits");
    // R7 quarter: 0x180 protected, 0x17F allowed
    wren("R7 set");
    wreq(9'h180, "R7 quarter start denied");
    wreq(9'h17F, "R7 below quarter granted");
    done("R7 end");
    wren("R7 set");
    wreq(9'h1FF, "R7 top denied");
    idle("R7 clear latch path");
    // R7 half
    set_bp(8'h08, "R7 set half");
    wren("R7 set");
    wreq(9'h100, "R7 half start denied");
    wreq(9'h0FF, "R7 below half granted");
    done("R7 end");
    // R7 whole
    set_bp(8'h0C, "R7 set whole");
    wren("R7 set");
    wreq(9'h000, "R7 whole denied");
    set_bp(8'h00, "R7 clear protection");
    wren("R7 set");
    wreq(9'h1FF, "R7 none granted");
    done("R7 end");
    // R3/R4 protect pin
    wren("R3 set before pin");
    idle("R3 pin low", 0);
    step(1, 0, 0, 0, 8'h00, '0, 0, 0, "R3 wren ignored pin low");
    step(0, 0, 1, 1, 8'h00, 9'h000, 0, 0, "R4 pin low deny");
    idle("R3 pin high latch still clear");
    // R8: pin drops during status write, cycle continues and commits
    wren("R8 set");
    sreq(8'h0C, "R8 status write whole");
    idle("R8 pin low busy", 0);
    idle("R8 pin low busy", 0);
    done("R8 end with pin low", 0);
    idle("R8 committed", 0);
    idle("R8 pin back");
    set_bp(8'h00, "R8 restore");
    // R9: both requests together
    wren("R9 set");
    step(0, 0, 1, 1, 8'h0C, 9'h040, 1, 0, "R9 array wins");
    idle("R9 busy array");
    done("R9 end");
    idle("R9 protect unchanged");
    repeat (2) @(negedge clk);
    #(CLK_P/2);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule